// File: doc/BRIEF.md
# Fully Associative Write-Back Second-Level Cache

This block is a second-level data cache placed between a first-level cache (or the arbiter in front of it) and a memory controller that moves whole 128-bit lines. The upstream side presents a request strobe, a read/write select, a byte address and a write word. It receives a stall flag and a read word. When the stall flag is low in a cycle with the request high, the access is complete: a read returns its word in that same cycle, and a write is committed at the next clock edge. The downstream side issues line reads and line writes with a request/ready handshake and holds the request until ready is seen.

Sixteen line slots are searched in parallel on every access, so any line may occupy any slot. Stores never go to memory directly. They mark the line dirty, and the line is written out only when it is replaced. The slot to replace comes from a round-robin pointer. When the chosen slot is dirty, its contents are copied into a one-line eviction buffer. The missing line is fetched first, and the buffered line is written back afterwards. While that writeback drains, accesses that hit are still served and only misses stall.

Top module: `l2wb_cache`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is zero, and no memory request is raised while the upstream side is idle.
- R2: A read hit returns the 32-bit word selected by address bits [3:2] (word n occupies bits 32n+31..32n of the line) with the stall flag low in the same cycle, and it raises no memory request.
- R3: A write hit replaces the selected word, marks the line dirty and causes no memory traffic; a later read of that word returns the new value.
- R4: A miss raises the stall flag in the cycle it is presented and issues a line read at line address = address bits [31:4]. The request, its address and its direction stay steady until ready. The access completes with the stall flag low in the cycle after ready.
- R5: Fills go to slots in the order 0, 1, 2, ... 15, 0, with the pointer advancing by one after each fill. The seventeenth distinct line therefore replaces the first line that was filled.
- R6: Replacing a clean line causes no memory write.
- R7: Replacing a dirty line first reads the missing line and then writes the old line, at its own line address, with all four of its words, including those modified by stores.
- R8: While a buffered line is being written back, a hit is served with the stall flag low, and a miss keeps the stall flag high until the writeback has finished and its own fill has been done.
- R9: A write miss fetches the line, then writes the word; the line is dirty afterwards and the other three words keep their memory values.
- R10: No address ever matches more than one slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Upstream access request |
| up_wr | input | 1 | 1 = store, 0 = load |
| up_addr | input | 32 | Byte address of the access |
| up_wdata | input | 32 | Store data |
| up_wait | output | 1 | Stall flag, high while the request cannot complete |
| up_rdata | output | 32 | Load data, valid when up_req is high and up_wait is low |
| mem_req | output | 1 | Line transfer request to memory |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 28 | Line address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Line returned by memory, valid with mem_ready |
| mem_ready | input | 1 | One-cycle completion of the current line transfer |

## Verification
The hardest case to reach is a dirty replacement whose writeback is still in flight when the next upstream accesses arrive. It needs all sixteen slots filled, stores made to the lines that will later be chosen, and the pointer walked all the way round. The bench runs a table of loads and stores that dirties the first two slots, then fills the remaining slots with loads. A seventeenth line forces a dirty eviction. Next comes a hit, which must be served while the line write is still pending. After that, a load of the evicted line misses during the drain. It must return the stored word and forces a second dirty eviction. A final miss on a clean victim checks that no write is issued.

// File: rtl/l2c_pkg.sv
package l2c_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } l2c_state_e;

endpackage

// File: rtl/l2c_tags.sv
module l2c_tags #(
  parameter int LINES = 16,
  parameter int TAG_W = 28,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic [IDX_W-1:0] vic_idx,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag
);

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [LINES-1:0] hit_vec;

  // one comparator per slot
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign hit_vec[i] = valid_q[i] && (tag_q[i] == look_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign vic_valid = valid_q[vic_idx];
  assign vic_dirty = dirty_q[vic_idx];
  assign vic_tag   = tag_q[vic_idx];

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= 1'b0;
    end else if (mark_en) begin
      dirty_q[mark_idx] <= 1'b1;
    end
  end

  // R10
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R3
  dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
    mark_en |=> dirty_q[$past(mark_idx)]);

  // R4
  fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));

endmodule

// File: rtl/l2c_data.sv
module l2c_data #(
  parameter int LINES      = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = $clog2(LINES),
  parameter int WSEL_W     = $clog2(LINE_WORDS),
  parameter int LINE_W     = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  vic_idx,
  output logic [LINE_W-1:0] vic_line,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data
);

  logic [WORD_W-1:0] lane_rd [LINE_WORDS];

  // one word-wide storage lane per word position
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_q [LINES];

    always_ff @(posedge clk) begin
      if (fill_en) begin
        lane_q[fill_idx] <= fill_line[w*WORD_W +: WORD_W];
      end else if (wr_en && (wr_word == WSEL_W'(w))) begin
        lane_q[wr_idx] <= wr_data;
      end
    end

    assign lane_rd[w]                    = lane_q[rd_idx];
    assign vic_line[w*WORD_W +: WORD_W]  = lane_q[vic_idx];
  end

  assign rd_data = lane_rd[rd_word];

endmodule

// File: rtl/l2c_wbuf.sv
module l2c_wbuf #(
  parameter int TAG_W  = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [LINE_W-1:0] load_line,
  input  logic              done,
  output logic              full,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] line
);

  logic full_q;

  always_ff @(posedge clk) begin
    if (rst)       full_q <= 1'b0;
    else if (load) full_q <= 1'b1;
    else if (done) full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag  <= load_tag;
      line <= load_line;
    end
  end

  assign full = full_q;

  // R7
  wbuf_single_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !full_q);

  // R7
  wbuf_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> full_q);

endmodule

// File: rtl/l2wb_cache.sv
module l2wb_cache
  import l2c_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int OFF_W     = WSEL_W + 2,
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(LINES),
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_wr,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [WORD_W-1:0] up_wdata,
  output logic              up_wait,
  output logic [WORD_W-1:0] up_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [TAG_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  l2c_state_e state_q, state_d;

  logic [TAG_W-1:0]  look_tag;
  logic [WSEL_W-1:0] look_word;
  logic              unused_lo;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  ptr_q;
  logic [TAG_W-1:0]  miss_tag_q;
  logic              fill_en, wr_en, wb_load, wb_done;
  logic              vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic [LINE_W-1:0] vic_line;
  logic              wb_full;
  logic [TAG_W-1:0]  wb_tag;
  logic [LINE_W-1:0] wb_line;

  assign look_tag  = up_addr[ADDR_W-1:OFF_W];
  assign look_word = up_addr[OFF_W-1:2];
  assign unused_lo = ^up_addr[1:0];

  l2c_tags #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .look_tag (look_tag),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .fill_en  (fill_en),
    .fill_idx (ptr_q),
    .fill_tag (miss_tag_q),
    .mark_en  (wr_en),
    .mark_idx (hit_idx),
    .vic_idx  (ptr_q),
    .vic_valid(vic_valid),
    .vic_dirty(vic_dirty),
    .vic_tag  (vic_tag)
  );

  l2c_data #(.LINES(LINES), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk      (clk),
    .rd_idx   (hit_idx),
    .rd_word  (look_word),
    .rd_data  (up_rdata),
    .vic_idx  (ptr_q),
    .vic_line (vic_line),
    .fill_en  (fill_en),
    .fill_idx (ptr_q),
    .fill_line(mem_rdata),
    .wr_en    (wr_en),
    .wr_idx   (hit_idx),
    .wr_word  (look_word),
    .wr_data  (up_wdata)
  );

  l2c_wbuf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_wbuf (
    .clk      (clk),
    .rst      (rst),
    .load     (wb_load),
    .load_tag (vic_tag),
    .load_line(vic_line),
    .done     (wb_done),
    .full     (wb_full),
    .tag      (wb_tag),
    .line     (wb_line)
  );

  always_comb begin
    state_d = state_q;
    up_wait = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    fill_en = 1'b0;
    wr_en   = 1'b0;
    wb_load = 1'b0;
    wb_done = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (up_req) begin
          if (hit) begin
            wr_en = up_wr;
          end else begin
            up_wait = 1'b1;
            wb_load = vic_valid && vic_dirty;
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        up_wait = up_req;
        mem_req = 1'b1;
        if (mem_ready) begin
          fill_en = 1'b1;
          state_d = wb_full ? ST_DRAIN : ST_IDLE;
        end
      end
      ST_DRAIN: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (up_req) begin
          if (hit) wr_en   = up_wr;
          else     up_wait = 1'b1;
        end
        if (mem_ready) begin
          wb_done = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_addr  = (state_q == ST_DRAIN) ? wb_tag : miss_tag_q;
  assign mem_wdata = wb_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fill_en) ptr_q <= (ptr_q == IDX_W'(LINES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && up_req && !hit) miss_tag_q <= look_tag;
  end

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7
  fill_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(state_q) == ST_FILL));

endmodule

// File: tb/sim_l2wb_cache.sv
`timescale 1ns/1ps
module sim_l2wb_cache;

  localparam int LAT = 3;

  typedef struct packed {
    logic        w;
    logic [27:0] tg;
    logic [1:0]  wd;
    logic [31:0] dat;
    logic [31:0] expd;
    logic        miss;
    logic [1:0]  ops;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 28'h100, 2'd1, 32'h0,        32'hC0001001, 1'b1, 2'd1},
    '{1'b0, 28'h100, 2'd3, 32'h0,        32'hC0001003, 1'b0, 2'd0},
    '{1'b1, 28'h100, 2'd2, 32'hDEAD0002, 32'h0,        1'b0, 2'd0},
    '{1'b0, 28'h100, 2'd2, 32'h0,        32'hDEAD0002, 1'b0, 2'd0},
    '{1'b1, 28'h101, 2'd0, 32'h11110000, 32'h0,        1'b1, 2'd1},
    '{1'b0, 28'h101, 2'd0, 32'h0,        32'h11110000, 1'b0, 2'd0},
    '{1'b0, 28'h101, 2'd1, 32'h0,        32'hC0001011, 1'b0, 2'd0},
    '{1'b0, 28'h102, 2'd0, 32'h0,        32'hC0001020, 1'b1, 2'd1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         up_req = 1'b0, up_wr = 1'b0;
  logic [31:0]  up_addr = '0, up_wdata = '0;
  logic         up_wait;
  logic [31:0]  up_rdata;
  logic         mem_req, mem_we;
  logic [27:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic        op_we   [64];
  logic [27:0] op_tag  [64];
  logic [127:0] op_line [64];
  int          op_n = 0;
  logic [27:0] ov_tag  [8];
  logic [127:0] ov_line [8];
  int          ov_n = 0;

  always #5 clk = ~clk;

  l2wb_cache u0 (
    .clk(clk), .rst(rst),
    .up_req(up_req), .up_wr(up_wr), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_wait(up_wait), .up_rdata(up_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [31:0] base_word(input logic [27:0] t, input int w);
    return 32'hC000_0000 | {t, 4'h0} | 32'(w);
  endfunction

  function automatic logic [127:0] mem_line(input logic [27:0] t);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = base_word(t, w);
    for (int i = 0; i < ov_n; i++) if (ov_tag[i] == t) l = ov_line[i];
    return l;
  endfunction

  // memory responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (mem_req && !rst) begin
        cnt++;
        if (cnt == LAT) begin
          cnt = 0;
          mem_ready = 1'b1;
          if (op_n < 64) begin
            op_we[op_n]   = mem_we;
            op_tag[op_n]  = mem_addr;
            op_line[op_n] = mem_we ? mem_wdata : mem_line(mem_addr);
          end
          op_n++;
          if (mem_we) begin
            if (ov_n < 8) begin
              ov_tag[ov_n]  = mem_addr;
              ov_line[ov_n] = mem_wdata;
              ov_n++;
            end
          end else begin
            mem_rdata = mem_line(mem_addr);
          end
        end
      end
    end
  end

  task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [27:0] tg, input logic [1:0] wd,
                        input logic [31:0] dat, output logic [31:0] rd,
                        output int stalls, output int ops, output logic drn);
    int ops0;
    ops0 = op_n;
    @(negedge clk);
    up_req = 1'b1; up_wr = w; up_addr = {tg, wd, 2'b00}; up_wdata = dat;
    #1;
    drn = mem_req && mem_we;
    stalls = 0;
    while (up_wait && stalls < 500) begin
      @(negedge clk); #1; stalls++;
    end
    rd = up_rdata;
    @(posedge clk); #1;
    up_req = 1'b0; up_wr = 1'b0;
    ops = op_n - ops0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string row_req(input int i);
    case (i)
      0, 7:    return "R4";
      1:       return "R2";
      2, 3:    return "R3";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int st, ops;
    logic drn;
    int n0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 mem_req idle", 128'(mem_req), 128'(0));
    check("R1 wait idle", 128'(up_wait), 128'(0));

    // vector table
    for (int i = 0; i < 8; i++) begin
      access(VEC[i].w, VEC[i].tg, VEC[i].wd, VEC[i].dat, rd, st, ops, drn);
      if (!VEC[i].w) check({row_req(i), " rdata"}, 128'(rd), 128'(VEC[i].expd));
      check({row_req(i), " miss"}, 128'(st != 0), 128'(VEC[i].miss));
      check({row_req(i), " memops"}, 128'(ops), 128'(VEC[i].ops));
      if (VEC[i].miss)
        check("R4 line addr", 128'(op_tag[op_n-1]), 128'(VEC[i].tg));
    end
    // R9 untouched words of the write-miss line
    access(1'b0, 28'h101, 2'd3, 32'h0, rd, st, ops, drn);
    check("R9 other word", 128'(rd), 128'(32'hC0001013));

    // R5 fill the remaining slots with clean lines
    for (int k = 3; k < 16; k++) begin
      access(1'b0, 28'(28'h100 + k), 2'd0, 32'h0, rd, st, ops, drn);
      check("R5 fill", 128'(rd), 128'(base_word(28'(28'h100 + k), 0)));
    end
    check("R5 reads so far", 128'(op_n), 128'(16));

    // seventeenth line evicts slot 0 (dirty line 0x100)
    access(1'b0, 28'h110, 2'd0, 32'h0, rd, st, ops, drn);
    check("R5 new line data", 128'(rd), 128'(32'hC0001100));
    check("R7 read first", 128'({op_we[16], op_tag[16]}), 128'({1'b0, 28'h110}));

    // R8 hit while the writeback drains
    access(1'b0, 28'h102, 2'd0, 32'h0, rd, st, ops, drn);
    check("R8 drain active", 128'(drn), 128'(1));
    check("R8 hit no stall", 128'(st), 128'(0));
    check("R8 hit data", 128'(rd), 128'(32'hC0001020));

    // R8 miss during drain on the evicted line
    access(1'b0, 28'h100, 2'd2, 32'h0, rd, st, ops, drn);
    check("R8 miss stalls", 128'(st != 0), 128'(1));
    check("R7 stored word kept", 128'(rd), 128'(32'hDEAD0002));
    check("R7 write addr", 128'({op_we[17], op_tag[17]}), 128'({1'b1, 28'h100}));
    check("R7 write line", op_line[17],
          {32'hC0001003, 32'hDEAD0002, 32'hC0001001, 32'hC0001000});
    check("R8 refetch after drain", 128'({op_we[18], op_tag[18]}), 128'({1'b0, 28'h100}));

    idle(12);
    // R5 pointer moved to slot 1 (dirty 0x101)
    check("R5 second victim", 128'({op_we[19], op_tag[19]}), 128'({1'b1, 28'h101}));
    check("R7 second line", op_line[19],
          {32'hC0001013, 32'hC0001012, 32'hC0001011, 32'h11110000});

    // R6 clean victim (slot 2, line 0x102)
    n0 = op_n;
    access(1'b0, 28'h111, 2'd1, 32'h0, rd, st, ops, drn);
    check("R6 data", 128'(rd), 128'(32'hC0001111));
    idle(12);
    check("R6 only one op", 128'(op_n - n0), 128'(1));
    check("R6 op is read", 128'(op_we[n0]), 128'(0));
    // R5 slot 2 was replaced: 0x102 now misses
    access(1'b0, 28'h102, 2'd0, 32'h0, rd, st, ops, drn);
    check("R5 replaced line misses", 128'(st != 0), 128'(1));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule